// File: doc/BRIEF.md
# UART Line Status Flag Logic

This block builds the eight-bit line status byte for one UART channel. It follows the occupancy of the transmit path: a transmit FIFO, or a single holding register when FIFO mode is off, feeding a shift register. It also owns the receive FIFO. Each received character is stored together with three error tags (parity, framing, break). The byte at the head of the FIFO shows its own tags, and a summary flag tells whether any stored byte still carries a tag. The serial shifters and the baud timing live elsewhere. They report to this block through strobes: the shifter takes a byte, the shifter is busy, a character has been assembled, and the current receive line level.

The host side sees write strobes for the transmit path, read strobes for the receive head and for the status byte, the head data byte and the status byte. A FIFO-mode level input picks 16-entry FIFOs or single-entry buffers. Any change of that input empties both paths. Every strobe is sampled on the rising clock edge, and its effect appears on the outputs from that edge onward. The one exception is the transmitter-empty bit, which also follows the shifter-busy input combinationally.

Top module: `uart_lsr_core`

## Requirements
- R1: After reset the status byte is 0x60 (bits 5 and 6 set, all others clear) and the data output is 0x00.
- R2: With FIFO mode off, the transmit path holds one byte. Bit 5 is low from the edge that samples a host write until the edge that samples a shifter load. A write while the byte is held is ignored.
- R3: With FIFO mode on, the transmit FIFO holds 16 bytes. Bit 5 is high exactly when it is empty. Writes to a full FIFO are ignored unless a load happens in the same cycle.
- R4: Bit 6 is high exactly when bit 5 is high and the shifter-busy input is low.
- R5: Bit 0 is high while the receive FIFO is nonempty. Bits 2, 3 and 4 show the parity, framing and break tags of the head entry. The data output is the head data byte. All of these read 0 when the FIFO is empty. A head read pops one entry.
- R6: The receive path holds 16 entries in FIFO mode and 1 otherwise. A character that arrives when the path is full, with no pop in the same cycle, is dropped and sets bit 1. Bit 1 clears on the edge after a status read. If a new overrun happens in the same cycle as the status read, bit 1 stays set.
- R7: Bit 7 is high while at least one stored entry has any tag set. It stays correct when a tagged push and a tagged pop happen in the same cycle.
- R8: While the receive line is low, only the first offered break character is stored. Later break offers are dropped without setting overrun until the line has been seen high.
- R9: A change of the FIFO-mode input empties both FIFOs on that edge. All push, pop, write and load strobes in that cycle are ignored.
- R10: When the receive FIFO is full, a push and a pop in the same cycle are both accepted, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects 16-entry FIFOs, 0 selects single buffers |
| thr_wr_i | input | 1 | Host writes one byte to the transmit path |
| tsr_load_i | input | 1 | Shifter takes the oldest transmit byte |
| tsr_busy_i | input | 1 | Shift register holds a character |
| rx_valid_i | input | 1 | Receiver delivers one character |
| rx_data_i | input | 8 | Received character |
| rx_perr_i | input | 1 | Parity error tag of the character |
| rx_ferr_i | input | 1 | Framing error tag of the character |
| rx_brk_i | input | 1 | Character is a break |
| rx_line_i | input | 1 | Current receive line level |
| rhr_rd_i | input | 1 | Host reads and pops the receive head |
| lsr_rd_i | input | 1 | Host reads the status byte |
| rx_data_o | output | 8 | Receive head data byte |
| lsr_o | output | 8 | Line status byte |

## Verification
Two collisions matter most. The first is a push and a pop on the receive FIFO in one cycle, both tagged, when the FIFO is full. The second is an overrun event in the same cycle as the status read that would clear the overrun bit. Directed sequences fill the FIFO to 16 entries and then strobe push with head read, and push with status read, on one edge. The judgement is that bit 1 stays clear in the first case and stays set in the second, and that bit 7 follows the tags that remain. The random phase mixes all strobes so that write and load on the transmit side also coincide. A bench model, written from the requirements, predicts every status bit each cycle.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef struct packed {
    logic brk;
    logic fer;
    logic per;
  } rx_tag_t;

  // status bit positions, decoded by host software
  localparam int unsigned LsrDr   = 0;
  localparam int unsigned LsrOe   = 1;
  localparam int unsigned LsrPe   = 2;
  localparam int unsigned LsrFe   = 3;
  localparam int unsigned LsrBi   = 4;
  localparam int unsigned LsrThre = 5;
  localparam int unsigned LsrTemt = 6;
  localparam int unsigned LsrErr  = 7;
endpackage

// File: rtl/lsr_tx_track.sv
module lsr_tx_track #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic fifo_mode_i,
  input  logic wr_i,
  input  logic load_i,
  output logic empty_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic          pop, push;

  always_comb begin
    cap   = fifo_mode_i ? CW'(DEPTH) : CW'(1);
    pop   = load_i && (cnt_q != '0) && !flush_i;
    push  = wr_i && !flush_i && ((cnt_q < cap) || pop);
    cnt_d = cnt_q;
    if (flush_i)         cnt_d = '0;
    else if (push && !pop) cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign empty_o = (cnt_q == '0);

  // R2
  wr_clears_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !flush_i) |=> !empty_o);

  // R3
  idle_keeps_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !load_i && !flush_i) |=> $stable(empty_o));
endmodule

// File: rtl/lsr_brk_gate.sv
module lsr_brk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_valid_i,
  input  logic rx_brk_i,
  input  logic rx_line_i,
  output logic drop_o
);
  logic blocked_q;
  logic brk_offer;

  assign brk_offer = rx_valid_i && rx_brk_i;
  assign drop_o    = brk_offer && blocked_q;

  // rearm only once the line is seen high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        blocked_q <= 1'b0;
    else if (rx_line_i) blocked_q <= 1'b0;
    else if (brk_offer) blocked_q <= 1'b1;
  end

  // R8
  one_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_offer && !rx_line_i) |=> (!brk_offer || drop_o));
endmodule

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
  import lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          fifo_mode_i,
  input  logic          push_req_i,
  input  logic [DW-1:0] data_i,
  input  rx_tag_t       tag_i,
  input  logic          pop_req_i,
  output logic [DW-1:0] head_data_o,
  output rx_tag_t       head_tag_o,
  output logic          nonempty_o,
  output logic          overrun_o,
  output logic          any_err_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] data_mem [DEPTH];
  rx_tag_t       tag_mem  [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, cnt_d, err_q, err_d, cap;
  logic          pop, push_acc, tag_in, tag_out;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    cap      = fifo_mode_i ? CW'(DEPTH) : CW'(1);
    pop      = pop_req_i && (cnt_q != '0) && !flush_i;
    push_acc = push_req_i && !flush_i && ((cnt_q < cap) || pop);
    tag_in   = |tag_i;
    tag_out  = |tag_mem[rd_ptr_q];
    cnt_d    = cnt_q;
    err_d    = err_q;
    if (flush_i) begin
      cnt_d = '0;
      err_d = '0;
    end else begin
      if (push_acc && !pop) cnt_d = cnt_q + CW'(1);
      if (pop && !push_acc) cnt_d = cnt_q - CW'(1);
      if ((push_acc && tag_in) && !(pop && tag_out)) err_d = err_q + CW'(1);
      if ((pop && tag_out) && !(push_acc && tag_in)) err_d = err_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      err_q    <= '0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (push_acc) wr_ptr_q <= ptr_inc(wr_ptr_q);
        if (pop)      rd_ptr_q <= ptr_inc(rd_ptr_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_acc) begin
      data_mem[wr_ptr_q] <= data_i;
      tag_mem[wr_ptr_q]  <= tag_i;
    end
  end

  assign nonempty_o  = (cnt_q != '0);
  assign head_data_o = nonempty_o ? data_mem[rd_ptr_q] : '0;
  assign head_tag_o  = nonempty_o ? tag_mem[rd_ptr_q] : '0;
  assign overrun_o   = push_req_i && !flush_i && !push_acc;
  assign any_err_o   = (err_q != '0);

  // R7
  err_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q <= cnt_q);

  // R7
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_acc && tag_in) |=> any_err_o);

  // R10
  full_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == cap) && push_req_i && pop) |=> $stable(cnt_q));
endmodule

// File: rtl/uart_lsr_core.sv
module uart_lsr_core
  import lsr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              thr_wr_i,
  input  logic              tsr_load_i,
  input  logic              tsr_busy_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  input  logic              rx_line_i,
  input  logic              rhr_rd_i,
  input  logic              lsr_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [7:0]        lsr_o
);
  logic    mode_q, flush;
  logic    tx_empty, brk_drop, rx_nonempty, ovr_evt, rx_any_err, ovr_q;
  rx_tag_t rx_tag, head_tag;

  assign flush  = (fifo_en_i != mode_q);
  assign rx_tag = '{brk: rx_brk_i, fer: rx_ferr_i, per: rx_perr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      mode_q <= fifo_en_i;
      if (ovr_evt)       ovr_q <= 1'b1;  // new event beats read clear
      else if (lsr_rd_i) ovr_q <= 1'b0;
    end
  end

  lsr_tx_track #(.DEPTH(FIFO_DEPTH)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .fifo_mode_i (mode_q),
    .wr_i        (thr_wr_i),
    .load_i      (tsr_load_i),
    .empty_o     (tx_empty)
  );

  lsr_brk_gate u_brk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_brk_i   (rx_brk_i),
    .rx_line_i  (rx_line_i),
    .drop_o     (brk_drop)
  );

  lsr_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(DATA_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .fifo_mode_i (mode_q),
    .push_req_i  (rx_valid_i && !brk_drop),
    .data_i      (rx_data_i),
    .tag_i       (rx_tag),
    .pop_req_i   (rhr_rd_i),
    .head_data_o (rx_data_o),
    .head_tag_o  (head_tag),
    .nonempty_o  (rx_nonempty),
    .overrun_o   (ovr_evt),
    .any_err_o   (rx_any_err)
  );

  always_comb begin
    lsr_o          = '0;
    lsr_o[LsrDr]   = rx_nonempty;
    lsr_o[LsrOe]   = ovr_q;
    lsr_o[LsrPe]   = head_tag.per;
    lsr_o[LsrFe]   = head_tag.fer;
    lsr_o[LsrBi]   = head_tag.brk;
    lsr_o[LsrThre] = tx_empty;
    lsr_o[LsrTemt] = tx_empty && !tsr_busy_i;
    lsr_o[LsrErr]  = rx_any_err;
  end

  // R4
  temt_thre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_o[LsrTemt] |-> lsr_o[LsrThre]);

  // R6
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt |=> lsr_o[LsrOe]);

  // R9
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (!lsr_o[LsrDr] && lsr_o[LsrThre] && !lsr_o[LsrErr]));

  // R5
  empty_tags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lsr_o[LsrDr] |-> (lsr_o[LsrBi:LsrPe] == 3'b000));
endmodule

// File: tb/uart_lsr_core_tb_top.sv
`timescale 1ns/1ps
module uart_lsr_core_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en = 0, thr_wr = 0, tsr_load = 0, tsr_busy = 0;
  logic       rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, rx_line = 1;
  logic       rhr_rd = 0, lsr_rd = 0;
  logic [7:0] rx_data = 0;
  logic [7:0] rx_data_o, lsr_o;

  int checks = 0;
  int fails  = 0;

  // model state: entry = {brk, fer, per, data}
  logic        m_mode = 0, m_ovr = 0, m_blk = 0;
  int          m_tx = 0;
  logic [10:0] q[$];

  always #2 clk_i = ~clk_i;

  uart_lsr_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .thr_wr_i(thr_wr),
    .tsr_load_i(tsr_load), .tsr_busy_i(tsr_busy), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr),
    .rx_brk_i(rx_brk), .rx_line_i(rx_line), .rhr_rd_i(rhr_rd),
    .lsr_rd_i(lsr_rd), .rx_data_o(rx_data_o), .lsr_o(lsr_o)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic model_update();
    bit flush, drop, pop, push, pv, acc, ovr_set;
    int cap;
    flush   = (fifo_en != m_mode);
    cap     = m_mode ? 16 : 1;
    drop    = rx_valid && rx_brk && m_blk;
    ovr_set = 0;
    if (flush) begin
      m_tx = 0;
      q.delete();
    end else begin
      pop  = tsr_load && (m_tx > 0);
      push = thr_wr && ((m_tx < cap) || pop);
      m_tx = m_tx + int'(push) - int'(pop);
      pop  = rhr_rd && (q.size() > 0);
      pv   = rx_valid && !drop;
      acc  = pv && ((q.size() < cap) || pop);
      if (pop) void'(q.pop_front());
      if (acc) q.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
      ovr_set = pv && !acc;
    end
    if (ovr_set)     m_ovr = 1;
    else if (lsr_rd) m_ovr = 0;
    m_blk  = rx_line ? 1'b0 : (m_blk || (rx_valid && rx_brk));
    m_mode = fifo_en;
  endtask

  task automatic compare_all();
    logic [10:0] h;
    logic        anyerr, thre;
    h = (q.size() > 0) ? q[0] : 11'd0;
    anyerr = 0;
    foreach (q[i]) if (q[i][10:8] != 3'b000) anyerr = 1;
    thre = (m_tx == 0);
    chk("R5 data ready", {7'd0, lsr_o[0]}, {7'd0, q.size() > 0});
    chk("R5 head data", rx_data_o, h[7:0]);
    chk("R5 head tags", {5'd0, lsr_o[4:2]}, {5'd0, h[10:8]});
    chk("R6 overrun", {7'd0, lsr_o[1]}, {7'd0, m_ovr});
    chk(m_mode ? "R3 thre fifo" : "R2 thre single", {7'd0, lsr_o[5]}, {7'd0, thre});
    chk("R4 temt", {7'd0, lsr_o[6]}, {7'd0, thre && !tsr_busy});
    chk("R7 any error", {7'd0, lsr_o[7]}, {7'd0, anyerr});
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    compare_all();
    thr_wr = 0; tsr_load = 0; rx_valid = 0; rx_perr = 0; rx_ferr = 0;
    rx_brk = 0; rhr_rd = 0; lsr_rd = 0; rx_data = 0;
  endtask

  task automatic push_rx(input logic [7:0] d, input logic p, input logic f, input logic b);
    rx_valid = 1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h51A7));
    repeat (3) @(negedge clk_i);
    chk("R1 reset status", lsr_o, 8'h60);
    chk("R1 reset data", rx_data_o, 8'h00);
    rst_ni = 1;
    @(negedge clk_i);
    compare_all();

    // R2 single-byte transmit path
    thr_wr = 1; tick();
    chk("R2 thre low after write", {7'd0, lsr_o[5]}, 8'd0);
    thr_wr = 1; tick();
    tsr_busy = 1; tsr_load = 1; tick();
    chk("R2 thre high after load", {7'd0, lsr_o[5]}, 8'd1);
    chk("R4 temt low while busy", {7'd0, lsr_o[6]}, 8'd0);
    tsr_busy = 0; tick();
    chk("R4 temt high when idle", {7'd0, lsr_o[6]}, 8'd1);

    // R3 FIFO mode transmit path
    fifo_en = 1; tick();
    for (int i = 0; i < 17; i++) begin thr_wr = 1; tick(); end
    for (int i = 0; i < 15; i++) begin tsr_load = 1; tick(); end
    chk("R3 thre low with one byte", {7'd0, lsr_o[5]}, 8'd0);
    tsr_load = 1; tick();
    chk("R3 thre high when drained", {7'd0, lsr_o[5]}, 8'd1);

    // R8 break gating
    rx_line = 0; push_rx(8'h00, 0, 1, 1); tick();
    chk("R8 break tag at head", {7'd0, lsr_o[4]}, 8'd1);
    push_rx(8'h00, 0, 1, 1); tick();
    rx_line = 1; tick();
    rhr_rd = 1; tick();
    chk("R8 single break stored", {7'd0, lsr_o[0]}, 8'd0);
    chk("R8 no overrun from drop", {7'd0, lsr_o[1]}, 8'd0);

    // R6 overrun and R10 full push with pop
    for (int i = 0; i < 16; i++) begin push_rx(8'(i + 1), 0, 0, 0); tick(); end
    push_rx(8'hEE, 0, 0, 0); tick();
    chk("R6 overrun set", {7'd0, lsr_o[1]}, 8'd1);
    push_rx(8'hEF, 0, 0, 0); lsr_rd = 1; tick();
    chk("R6 set wins over clear", {7'd0, lsr_o[1]}, 8'd1);
    lsr_rd = 1; tick();
    chk("R6 read clears overrun", {7'd0, lsr_o[1]}, 8'd0);
    push_rx(8'hA5, 1, 0, 0); rhr_rd = 1; tick();
    chk("R10 full swap no overrun", {7'd0, lsr_o[1]}, 8'd0);
    chk("R10 full swap head", rx_data_o, 8'h02);
    chk("R7 summary with tagged tail", {7'd0, lsr_o[7]}, 8'd1);
    for (int i = 0; i < 15; i++) begin rhr_rd = 1; tick(); end
    chk("R7 tagged head parity", {7'd0, lsr_o[2]}, 8'd1);
    push_rx(8'h3C, 0, 1, 0); rhr_rd = 1; tick();
    chk("R7 tagged push and pop", {7'd0, lsr_o[7]}, 8'd1);
    rhr_rd = 1; tick();
    chk("R7 summary clears", {7'd0, lsr_o[7]}, 8'd0);

    // R9 mode change flush
    push_rx(8'h77, 1, 1, 0); thr_wr = 1; tick();
    fifo_en = 0; push_rx(8'h11, 0, 0, 0); thr_wr = 1; tick();
    chk("R9 flush rx", {7'd0, lsr_o[0]}, 8'd0);
    chk("R9 flush tx", {7'd0, lsr_o[5]}, 8'd1);
    chk("R9 flush summary", {7'd0, lsr_o[7]}, 8'd0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(199) == 0) fifo_en = ~fifo_en;
      tsr_busy = ($urandom_range(3) == 0);
      rx_line  = ($urandom_range(9) != 0);
      thr_wr   = ($urandom_range(2) == 0);
      tsr_load = ($urandom_range(2) == 0);
      rhr_rd   = ($urandom_range(2) == 0);
      lsr_rd   = ($urandom_range(5) == 0);
      if ($urandom_range(1) == 0)
        push_rx(8'($urandom), ($urandom_range(5) == 0), ($urandom_range(5) == 0),
                ($urandom_range(7) == 0));
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule